// File: doc/BRIEF.md
# Multiprocessor External Interrupt Distributor

This block fans a set of level-sensitive external interrupt lines out to several processor cores. Each line is first gated by a global enable mask. A global software-assert mask is then ORed in, so that software can raise any line by itself. The result is steered to cores through one routing word per line. Each core sees its routed lines shifted up by two bit positions, merged with a 3-bit inter-processor interrupt vector that arrives from outside.

A single-cycle register port gives access to the routing words, the enable and assert masks, a run-stall mask with one stall output per core, and a one-bit configuration register per core. It also returns an identification word. Each access carries the index of the core making it, which selects the per-core configuration bit and is echoed in the identification word. Line 0 is reserved: the external input vector feeds lines 1 and up, and line 0 can only be raised through the assert mask. Reset routes every line to core 0 and stalls every other core.

Top module: `irq_distributor`

## Requirements
- R1: One clock edge after any change of its inputs, the output of core c (bits [c*(N_LINES+2) +: N_LINES+2] of irq_out) equals {(((line_state & enable) | assert) & route_c), 2'b00} OR the zero-extended ipi_in[c*3 +: 3], where bit l of route_c is bit c of line l's routing word. The low three bits overlap the line 0 bit by OR.
- R2: A write to offset l with l < N_LINES stores the low N_CORES bits of the data as line l's routing word, and a read of offset l returns that word zero-extended.
- R3: A write to offset 0x180 clears the enable bits where the data holds ones. A write to 0x184 sets them. A read of 0x180 returns the enable mask.
- R4: A write to offset 0x188 clears the assert bits where the data holds ones. A write to 0x18C sets them. A read of 0x188 returns the assert mask.
- R5: A read of offset 0x1A0 returns ((N_CORES-1) << 18) | reg_core.
- R6: Offset 0x200 stores an N_CORES-bit run-stall mask. A read returns it, and stall_out bit c equals mask bit c one edge after the write.
- R7: Offset 0x220 holds one bit per core, namely bit 0 of the data, written and read for the core named by reg_core. The other cores' bits are left untouched.
- R8: After reset every routing word is 1, all N_LINES enable bits are set, assert is clear, the run-stall mask has every bit set except bit 0, all configuration bits are 0 and irq_out is 0.
- R9: Bit k of ext_irq drives line k+1. Line 0 is never driven by an external input.
- R10: A read of any other offset, including 0x184, 0x18C and routing offsets at or above N_LINES, returns zero. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_core | input | CORE_W | Index of the core making the access |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| ext_irq | input | N_EXT | External interrupt levels; bit k feeds line k+1 |
| ipi_in | input | 3*N_CORES | Inter-processor interrupt vector, 3 bits per core |
| irq_out | output | N_CORES*(N_LINES+2) | Registered per-core interrupt vectors |
| stall_out | output | N_CORES | Per-core run-stall outputs |

## Verification
The bench walks a vector table through routing, mask and input changes and compares every core's vector against a mask model held in the bench. The table includes the line 0 bit landing on top of the inter-processor bits. A design that forgot the OR, or that let the assert mask bypass routing, would show the wrong core bits there. Directed checks cover the reset map, the off-by-one mapping of external inputs to lines, the identification word, and per-core isolation of the configuration bit. A design with an off-by-one mapping would light bit 2 instead of bit 3. One that shared the configuration bit across cores would read 1 on core 0. Writes to a routing offset just past the last line and to a hole in the map are followed by readback, because a decoder that aliased them would corrupt a live routing word or mask.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
   localparam int unsigned OFS_EN_CLR = 'h180;
   localparam int unsigned OFS_EN_SET = 'h184;
   localparam int unsigned OFS_AS_CLR = 'h188;
   localparam int unsigned OFS_AS_SET = 'h18C;
   localparam int unsigned OFS_ID     = 'h1A0;
   localparam int unsigned OFS_STALL  = 'h200;
   localparam int unsigned OFS_CFG    = 'h220;
   localparam int unsigned ID_CORES_LSB = 18;

   typedef enum logic [1:0] {
      MOP_NONE = 2'd0,
      MOP_CLR  = 2'd1,
      MOP_SET  = 2'd2
   } mask_op_e;
endpackage

// File: rtl/irq_dist_mask_reg.sv
module irq_dist_mask_reg
   import irq_dist_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  mask_op_e     op,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q,
   output logic [W-1:0] d
);
   always_comb begin
      case (op)
         MOP_CLR: d = q & ~bits;
         MOP_SET: d = q | bits;
         default: d = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/irq_dist_route_bank.sv
module irq_dist_route_bank #(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned N_CORES = 4,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [N_LINES-1:0][N_CORES-1:0]   rt_q,
   output logic [N_LINES-1:0][N_CORES-1:0]   rt_d
);
   localparam logic [N_CORES-1:0] RT_RST = N_CORES'(1);

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      logic               hit;
      logic [N_CORES-1:0] word_q;
      assign hit = we && (addr == ADDR_W'(l));
      assign rt_d[l] = hit ? wdata[N_CORES-1:0] : word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= RT_RST;
         else        word_q <= rt_d[l];
      end
      assign rt_q[l] = word_q;
   end
endmodule

// File: rtl/irq_dist_core_ctl.sv
module irq_dist_core_ctl
   import irq_dist_pkg::*;
#(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CORE_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [CORE_W-1:0]  core,
   output logic [N_CORES-1:0] stall_q,
   output logic               cfg_rd
);
   localparam logic [N_CORES-1:0] STALL_RST = {N_CORES{1'b1}} & ~N_CORES'(1);

   logic               stall_hit;
   logic [N_CORES-1:0] cfg_q;

   assign stall_hit = we && (addr == ADDR_W'(OFS_STALL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stall_q <= STALL_RST;
      else if (stall_hit) stall_q <= wdata[N_CORES-1:0];
   end

   for (genvar c = 0; c < N_CORES; c++) begin : g_cfg
      logic hit;
      assign hit = we && (addr == ADDR_W'(OFS_CFG)) && (core == CORE_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cfg_q[c] <= 1'b0;
         else if (hit) cfg_q[c] <= wdata[0];
      end
   end

   always_comb begin
      cfg_rd = 1'b0;
      for (int c = 0; c < N_CORES; c++) begin
         if (core == CORE_W'(c)) cfg_rd = cfg_q[c];
      end
   end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irq_dist_pkg::*;
#(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned N_EXT   = 7,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned N_LINES = N_EXT + 1,
   localparam int unsigned OUT_W   = N_LINES + 2,
   localparam int unsigned CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   input  logic [CORE_W-1:0]          reg_core,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic [N_EXT-1:0]           ext_irq,
   input  logic [3*N_CORES-1:0]       ipi_in,
   output logic [N_CORES*OUT_W-1:0]   irq_out,
   output logic [N_CORES-1:0]         stall_out
);
   localparam int unsigned LIW = $clog2(N_LINES);

   if (N_CORES < 1 || N_CORES > 32) begin : g_bad_cores
      $error("irq_distributor: N_CORES must be 1..32");
   end
   if (N_EXT < 1 || N_EXT > 31) begin : g_bad_ext
      $error("irq_distributor: N_EXT must be 1..31");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("irq_distributor: ADDR_W must be at least 10");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("irq_distributor: DATA_W must be at least 32");
   end

   mask_op_e                         en_op, as_op;
   logic [N_LINES-1:0]               en_q, en_d, as_q, as_d;
   logic [N_LINES-1:0][N_CORES-1:0]  rt_q, rt_d;
   logic                             cfg_rd;
   logic [N_LINES-1:0]               line_state;
   logic [N_LINES-1:0]               pend;

   always_comb begin
      en_op = MOP_NONE;
      as_op = MOP_NONE;
      if (reg_we) begin
         if (reg_addr == ADDR_W'(OFS_EN_CLR)) en_op = MOP_CLR;
         if (reg_addr == ADDR_W'(OFS_EN_SET)) en_op = MOP_SET;
         if (reg_addr == ADDR_W'(OFS_AS_CLR)) as_op = MOP_CLR;
         if (reg_addr == ADDR_W'(OFS_AS_SET)) as_op = MOP_SET;
      end
   end

   irq_dist_mask_reg #(.W(N_LINES), .RST_VAL({N_LINES{1'b1}})) u_en (
      .clk(clk), .rst_n(rst_n), .op(en_op),
      .bits(reg_wdata[N_LINES-1:0]), .q(en_q), .d(en_d)
   );

   irq_dist_mask_reg #(.W(N_LINES), .RST_VAL('0)) u_as (
      .clk(clk), .rst_n(rst_n), .op(as_op),
      .bits(reg_wdata[N_LINES-1:0]), .q(as_q), .d(as_d)
   );

   irq_dist_route_bank #(
      .N_LINES(N_LINES), .N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rt_q(rt_q), .rt_d(rt_d)
   );

   irq_dist_core_ctl #(
      .N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_W(CORE_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .core(reg_core), .stall_q(stall_out), .cfg_rd(cfg_rd)
   );

   // line 0 is reserved for software; external inputs start at line 1
   assign line_state = {ext_irq, 1'b0};
   assign pend       = (line_state & en_d) | as_d;

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      logic [N_LINES-1:0] sel;
      logic [OUT_W-1:0]   vec_d, vec_q;
      for (genvar l = 0; l < N_LINES; l++) begin : g_sel
         assign sel[l] = rt_d[l][c];
      end
      assign vec_d = {pend & sel, 2'b00} | OUT_W'(ipi_in[3*c +: 3]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vec_q <= '0;
         else        vec_q <= vec_d;
      end
      assign irq_out[c*OUT_W +: OUT_W] = vec_q;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr < ADDR_W'(N_LINES)) begin
         reg_rdata = DATA_W'(rt_q[reg_addr[LIW-1:0]]);
      end else begin
         case (reg_addr)
            ADDR_W'(OFS_EN_CLR): reg_rdata = DATA_W'(en_q);
            ADDR_W'(OFS_AS_CLR): reg_rdata = DATA_W'(as_q);
            ADDR_W'(OFS_ID):     reg_rdata = (DATA_W'(N_CORES - 1) << ID_CORES_LSB)
                                             | DATA_W'(reg_core);
            ADDR_W'(OFS_STALL):  reg_rdata = DATA_W'(stall_out);
            ADDR_W'(OFS_CFG):    reg_rdata = DATA_W'(cfg_rd);
            default:             reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk
   import irq_dist_pkg::*;
#(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned N_LINES = 8,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CORE_W  = 2
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              reg_we,
   input logic [ADDR_W-1:0]                 reg_addr,
   input logic [DATA_W-1:0]                 reg_wdata,
   input logic [CORE_W-1:0]                 reg_core,
   input logic [DATA_W-1:0]                 reg_rdata,
   input logic [3*N_CORES-1:0]              ipi_in,
   input logic [N_CORES*(N_LINES+2)-1:0]    irq_out,
   input logic [N_CORES-1:0]                stall_out,
   input logic [N_LINES-1:0]                en_q,
   input logic [N_LINES-1:0]                as_q
);
   localparam int unsigned OW = N_LINES + 2;
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R3: clear and set of the enable mask
   a_r3_en_clear: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(reg_we && reg_addr == ADDR_W'(OFS_EN_CLR)) |->
         ((en_q & $past(reg_wdata[N_LINES-1:0])) == '0));
   a_r3_en_set: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(reg_we && reg_addr == ADDR_W'(OFS_EN_SET)) |->
         ((en_q & $past(reg_wdata[N_LINES-1:0])) == $past(reg_wdata[N_LINES-1:0])));

   // R4: clear and set of the assert mask
   a_r4_as_clear: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(reg_we && reg_addr == ADDR_W'(OFS_AS_CLR)) |->
         ((as_q & $past(reg_wdata[N_LINES-1:0])) == '0));
   a_r4_as_set: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(reg_we && reg_addr == ADDR_W'(OFS_AS_SET)) |->
         ((as_q & $past(reg_wdata[N_LINES-1:0])) == $past(reg_wdata[N_LINES-1:0])));

   // R5: identification word
   a_r5_id_word: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_ID)) |->
         (reg_rdata == ((DATA_W'(N_CORES - 1) << ID_CORES_LSB) | DATA_W'(reg_core))));

   // R6: stall outputs follow the written mask
   a_r6_stall_follow: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(reg_we && reg_addr == ADDR_W'(OFS_STALL)) |->
         (stall_out == $past(reg_wdata[N_CORES-1:0])));

   // R10: set-alias offsets read as zero
   a_r10_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_EN_SET) || reg_addr == ADDR_W'(OFS_AS_SET)) |->
         (reg_rdata == '0));

   // R1: inter-processor bits always reach the low bits of each core
   for (genvar c = 0; c < N_CORES; c++) begin : g_ipi
      a_r1_ipi_merge: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ((irq_out[c*OW +: 3] & $past(ipi_in[3*c +: 3])) == $past(ipi_in[3*c +: 3])));
   end
endmodule

bind irq_distributor irq_distributor_chk #(
   .N_CORES(N_CORES), .N_LINES(N_LINES), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .CORE_W(CORE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_core(reg_core), .reg_rdata(reg_rdata),
   .ipi_in(ipi_in), .irq_out(irq_out), .stall_out(stall_out),
   .en_q(en_q), .as_q(as_q)
);

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NE = 7;
   localparam int NL = NE + 1;
   localparam int OW = NL + 2;

   typedef struct packed {
      logic        we;
      logic [9:0]  addr;
      logic [31:0] data;
      logic [6:0]  ext;
      logic [11:0] ipi;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{1'b0, 10'h000, 32'h0,  7'h01, 12'h000},  // line1 to core0
      '{1'b1, 10'h001, 32'h6,  7'h01, 12'h000},  // line1 to cores 1,2
      '{1'b1, 10'h180, 32'h2,  7'h01, 12'h000},  // disable line1
      '{1'b1, 10'h18C, 32'h81, 7'h01, 12'h000},  // assert lines 0 and 7
      '{1'b0, 10'h000, 32'h0,  7'h7F, 12'h140},  // ipi core2 = 101
      '{1'b1, 10'h184, 32'hFF, 7'h7F, 12'h140},  // enable all
      '{1'b1, 10'h188, 32'h80, 7'h7F, 12'h007},  // drop assert line7
      '{1'b1, 10'h005, 32'hF,  7'h10, 12'h007},  // line5 to all
      '{1'b1, 10'h000, 32'h8,  7'h10, 12'h200},  // line0 to core3
      '{1'b1, 10'h1F0, 32'hFF, 7'h10, 12'h200},  // hole in map
      '{1'b1, 10'h008, 32'hF,  7'h10, 12'h000},  // past last line
      '{1'b0, 10'h000, 32'h0,  7'h00, 12'h000}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 reg_we = 1'b0;
   logic [9:0]           reg_addr = '0;
   logic [31:0]          reg_wdata = '0;
   logic [1:0]           reg_core = '0;
   logic [31:0]          reg_rdata;
   logic [NE-1:0]        ext_irq = '0;
   logic [3*NC-1:0]      ipi_in = '0;
   logic [NC*OW-1:0]     irq_out;
   logic [NC-1:0]        stall_out;

   int n_tests = 0;
   int n_fail  = 0;

   logic [NL-1:0]          m_en;
   logic [NL-1:0]          m_as;
   logic [NL-1:0][NC-1:0]  m_rt;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_distributor u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_core(reg_core), .reg_rdata(reg_rdata),
      .ext_irq(ext_irq), .ipi_in(ipi_in), .irq_out(irq_out), .stall_out(stall_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [9:0] a, input logic [31:0] d);
      if (a < 10'(NL))       m_rt[a[2:0]] = d[NC-1:0];
      else if (a == 10'h180) m_en = m_en & ~d[NL-1:0];
      else if (a == 10'h184) m_en = m_en | d[NL-1:0];
      else if (a == 10'h188) m_as = m_as & ~d[NL-1:0];
      else if (a == 10'h18C) m_as = m_as | d[NL-1:0];
   endtask

   function automatic logic [NC*OW-1:0] model_irq(input logic [NE-1:0] ext,
                                                  input logic [3*NC-1:0] ipi);
      logic [NC*OW-1:0] r;
      logic [NL-1:0]    p;
      logic [NL-1:0]    s;
      p = ({ext, 1'b0} & m_en) | m_as;
      for (int c = 0; c < NC; c++) begin
         for (int l = 0; l < NL; l++) s[l] = m_rt[l][c];
         r[c*OW +: OW] = {p & s, 2'b00} | OW'(ipi[3*c +: 3]);
      end
      return r;
   endfunction

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      m_en = '1; m_as = '0;
      for (int l = 0; l < NL; l++) m_rt[l] = NC'(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      chk("R8 irq_out", 64'(irq_out), 64'h0);
      chk("R8 stall_out", 64'(stall_out), 64'hE);
      for (int l = 0; l < NL; l++) begin
         rd(10'(l), v);
         chk("R8 route", 64'(v), 64'h1);
      end
      rd(10'h180, v); chk("R8 enable", 64'(v), 64'hFF);
      rd(10'h188, v); chk("R8 assert", 64'(v), 64'h0);
      rd(10'h200, v); chk("R8 stall", 64'(v), 64'hE);
      rd(10'h220, v); chk("R8 cfg", 64'(v), 64'h0);

      // R9: ext bit 0 lands on line 1 (output bit 3), never line 0
      @(negedge clk); ext_irq = 7'h01;
      @(negedge clk);
      chk("R9 ext0 to line1", 64'(irq_out), 64'h8);
      ext_irq = '0;
      @(negedge clk);

      // R1 R2 R3 R4 R10: vector table against the model
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         ext_irq = TBL[i].ext; ipi_in = TBL[i].ipi;
         reg_we = TBL[i].we; reg_addr = TBL[i].addr; reg_wdata = TBL[i].data;
         if (TBL[i].we) model_write(TBL[i].addr, TBL[i].data);
         @(negedge clk);
         reg_we = 1'b0;
         chk($sformatf("R1 vector %0d", i), 64'(irq_out), 64'(model_irq(TBL[i].ext, TBL[i].ipi)));
      end

      // R2 R10: readback after aliasing writes
      rd(10'h000, v); chk("R2 route line0", 64'(v), 64'h8);
      rd(10'h005, v); chk("R2 route line5", 64'(v), 64'hF);
      rd(10'h008, v); chk("R10 route past end", 64'(v), 64'h0);
      rd(10'h1F0, v); chk("R10 hole read", 64'(v), 64'h0);
      rd(10'h184, v); chk("R10 enable set alias", 64'(v), 64'h0);
      rd(10'h18C, v); chk("R10 assert set alias", 64'(v), 64'h0);
      rd(10'h180, v); chk("R3 enable readback", 64'(v), 64'(m_en));
      rd(10'h188, v); chk("R4 assert readback", 64'(v), 64'(m_as));

      // R5: identification word
      reg_core = 2'd2;
      rd(10'h1A0, v); chk("R5 id core2", 64'(v), 64'h000C0002);

      // R7: per-core configuration bit
      reg_core = 2'd1;
      wr(10'h220, 32'h3);
      rd(10'h220, v); chk("R7 cfg core1", 64'(v), 64'h1);
      reg_core = 2'd0;
      rd(10'h220, v); chk("R7 cfg core0 untouched", 64'(v), 64'h0);

      // R6: run-stall mask
      wr(10'h200, 32'h5);
      chk("R6 stall_out", 64'(stall_out), 64'h5);
      rd(10'h200, v); chk("R6 stall read", 64'(v), 64'h5);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule